// File: doc/BRIEF.md
# Interrupt Distributor Security-Aware Control Register

This block holds the global control word of an interrupt distributor: the enables for the three interrupt groups, the routing-enable flags and a bit that turns off security. Software reaches it through a simple word-addressed register port. Each access carries a secure attribute. A secure access sees and writes the whole control word. A non-secure access sees a small remapped alias of it and can change only the non-secure group-1 enable. A second, read-only word reports the interrupt line count, taken from a configured interrupt count, together with the identifier width and the security-extension state.

Setting the security-disable bit collapses the block to a single security state. The secure group-1 enable and the non-secure routing flag are forced to zero. From then on both kinds of access see the same full view, and the bit stays set until reset. The group-enable and routing outputs come straight from the state registers, so other distributor logic sees a new value on the cycle after the write that caused it. Read data is registered and appears one cycle after the request, marked by a valid strobe.

Word address 0 selects the control word and word address 1 selects the type word. Other addresses read as zero and ignore writes.

Top module: `dist_sec_ctrl`

## Requirements
- R1: After reset all three group enables are 0, the security-disable bit is 0 and the non-secure routing flag is 1. A secure read of the control word returns 0x00000030.
- R2: With security enabled, a secure write to the control word loads the group-0 enable (bit 0), the non-secure group-1 enable (bit 1) and the secure group-1 enable (bit 2). All other written bits are ignored. Bit 31 (write pending) and bit 7 (wake-up enable) always read 0, and bit 4 (secure routing) always reads 1.
- R3: With security enabled, a non-secure read of the control word returns the non-secure group-1 enable in bit 1 and the non-secure routing flag (secure bit 5) in bit 4. Bit 31 reads 0, and every other bit reads 0.
- R4: With security enabled, a non-secure write changes only the non-secure group-1 enable, from bit 1 of the written data. It cannot set the security-disable bit.
- R5: A secure write with bit 6 set while security is enabled sets the security-disable bit. The same write clears the secure group-1 enable and the non-secure routing flag, and loads bits 0 and 1 from the written data.
- R6: Once set, the security-disable bit ignores all writes and is cleared only by reset.
- R7: With security disabled, secure and non-secure reads both return the full view: bit 6 = 1, bit 4 = 1, bit 5 = 0, bit 2 = 0 and bits 1:0 holding the enables. A write of either attribute changes only bits 1:0.
- R8: The type word returns the interrupt count divided by 32, minus 1, in bits 4:0, and 0xF in bits 23:19. Bit 10 holds the inverse of the security-disable bit, bit 16 (message-based interrupts) reads 0, and all other bits read 0. Writes to it have no effect. The count must be at least 32.
- R9: Read data is valid, with the valid strobe high, exactly one cycle after a read request, and only then. Unmapped word addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| accEn | input | 1 | Access request this cycle |
| accWr | input | 1 | 1 = write, 0 = read |
| accSecure | input | 1 | Secure attribute of the access |
| accAddr | input | ADDR_W | Word address (0 control, 1 type) |
| wrData | input | 32 | Write data |
| irqCount | input | CNT_W | Configured number of interrupts |
| rdData | output | 32 | Registered read data |
| rdValid | output | 1 | Read data valid |
| grp0En | output | 1 | Group-0 enable |
| grp1NsEn | output | 1 | Non-secure group-1 enable |
| grp1SEn | output | 1 | Secure group-1 enable |
| routeEnS | output | 1 | Secure routing enable (always 1) |
| routeEnNs | output | 1 | Non-secure routing enable |
| secDisabled | output | 1 | Security-disable state |

## Verification
The control word is driven by all-ones and all-zeros writes and by single-bit writes under both attributes. An all-ones secure write shows which bits the write mask lets through. Non-secure all-ones and all-zeros writes show that only the bit 1 alias moves and that the disable bit cannot be reached. The same reads are repeated before and after the security-disable transition, which tells the remapped non-secure alias apart from the collapsed full view. Type-word reads at several interrupt counts, and writes to read-only and unmapped words, tell the line-count arithmetic apart from the constant fields and show that stray writes leave the outputs untouched.

// File: rtl/dist_sec_pkg.sv
package dist_sec_pkg;

  // Control word bit positions (software decodes these)
  localparam int CtlGrp0Bit   = 0;
  localparam int CtlGrp1NsBit = 1;
  localparam int CtlGrp1SBit  = 2;
  localparam int CtlRouteSBit = 4;
  localparam int CtlRouteNsBit = 5;
  localparam int CtlSecOffBit = 6;
  localparam int CtlWakeBit   = 7;
  localparam int CtlPendBit   = 31;

  // Type word fields
  localparam int TypLinesLsb  = 0;
  localparam int TypLinesW    = 5;
  localparam int TypSecExtBit = 10;
  localparam int TypMsgBit    = 16;
  localparam int TypIdLsb     = 19;
  localparam int TypIdW       = 5;
  localparam logic [TypIdW-1:0] TypIdVal = 5'hF;

  // Strobes from decode to the register datapath
  typedef struct packed {
    logic wrCtl;     // write hits the control word
    logic rdCtl;     // read hits the control word
    logic rdTyp;     // read hits the type word
    logic rdReq;     // any read request
    logic fullView;  // access sees the full (secure) view
    logic nsOnly;    // restricted non-secure write mask applies
  } strobe_t;

endpackage

// File: rtl/dist_sec_decode.sv
module dist_sec_decode
  import dist_sec_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              accEn,
  input  logic              accWr,
  input  logic              accSecure,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              secOffState,
  output strobe_t           strb
);

  localparam logic [ADDR_W-1:0] CtlAddr = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] TypAddr = ADDR_W'(1);

  logic hitCtl;
  logic hitTyp;

  always_comb begin
    hitCtl = (accAddr == CtlAddr);
    hitTyp = (accAddr == TypAddr);
    strb.wrCtl    = accEn && accWr && hitCtl;
    strb.rdCtl    = accEn && !accWr && hitCtl;
    strb.rdTyp    = accEn && !accWr && hitTyp;
    strb.rdReq    = accEn && !accWr;
    // Once security is off there is one state; attribute no longer matters
    strb.fullView = accSecure || secOffState;
    strb.nsOnly   = !accSecure && !secOffState;
  end

endmodule

// File: rtl/dist_sec_regs.sv
module dist_sec_regs
  import dist_sec_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [31:0]      wrData,
  input  logic [CNT_W-1:0] irqCount,
  output logic [31:0]      rdData,
  output logic             rdValid,
  output logic             grp0En,
  output logic             grp1NsEn,
  output logic             grp1SEn,
  output logic             routeEnNs,
  output logic             secOff
);

  logic [31:0]      fullWord;
  logic [31:0]      nsWord;
  logic [31:0]      typWord;
  logic [31:0]      rdNext;
  logic [CNT_W-1:0] lineCalc;
  logic             unusedBits;

  // State update: write masks depend on view and on security state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grp0En    <= 1'b0;
      grp1NsEn  <= 1'b0;
      grp1SEn   <= 1'b0;
      routeEnNs <= 1'b1;
      secOff    <= 1'b0;
    end else if (strb.wrCtl) begin
      if (strb.nsOnly) begin
        grp1NsEn <= wrData[CtlGrp1NsBit];
      end else begin
        grp0En   <= wrData[CtlGrp0Bit];
        grp1NsEn <= wrData[CtlGrp1NsBit];
        if (!secOff) begin
          if (wrData[CtlSecOffBit]) begin
            secOff    <= 1'b1;
            grp1SEn   <= 1'b0;
            routeEnNs <= 1'b0;
          end else begin
            grp1SEn <= wrData[CtlGrp1SBit];
          end
        end
      end
    end
  end

  // Read views
  always_comb begin
    fullWord = '0;
    fullWord[CtlGrp0Bit]    = grp0En;
    fullWord[CtlGrp1NsBit]  = grp1NsEn;
    fullWord[CtlGrp1SBit]   = grp1SEn;
    fullWord[CtlRouteSBit]  = 1'b1;
    fullWord[CtlRouteNsBit] = routeEnNs;
    fullWord[CtlSecOffBit]  = secOff;
    fullWord[CtlWakeBit]    = 1'b0;
    fullWord[CtlPendBit]    = 1'b0;

    nsWord = '0;
    nsWord[CtlGrp1NsBit] = grp1NsEn;
    nsWord[CtlRouteSBit] = routeEnNs;
    nsWord[CtlPendBit]   = 1'b0;

    lineCalc = (irqCount >> 5) - CNT_W'(1);
    typWord = '0;
    typWord[TypLinesLsb +: TypLinesW] = lineCalc[TypLinesW-1:0];
    typWord[TypSecExtBit]             = !secOff;
    typWord[TypMsgBit]                = 1'b0;
    typWord[TypIdLsb +: TypIdW]       = TypIdVal;

    if (strb.rdCtl)      rdNext = strb.fullView ? fullWord : nsWord;
    else if (strb.rdTyp) rdNext = typWord;
    else                 rdNext = '0;
  end

  assign unusedBits = ^{irqCount[4:0], lineCalc[CNT_W-1:TypLinesW]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdReq;
      rdData  <= strb.rdReq ? rdNext : '0;
    end
  end

endmodule

// File: rtl/dist_sec_ctrl.sv
module dist_sec_ctrl
  import dist_sec_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accEn,
  input  logic              accWr,
  input  logic              accSecure,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [31:0]       wrData,
  input  logic [CNT_W-1:0]  irqCount,
  output logic [31:0]       rdData,
  output logic              rdValid,
  output logic              grp0En,
  output logic              grp1NsEn,
  output logic              grp1SEn,
  output logic              routeEnS,
  output logic              routeEnNs,
  output logic              secDisabled
);

  strobe_t strb;

  dist_sec_decode #(.ADDR_W(ADDR_W)) u_dec (
    .accEn       (accEn),
    .accWr       (accWr),
    .accSecure   (accSecure),
    .accAddr     (accAddr),
    .secOffState (secDisabled),
    .strb        (strb)
  );

  dist_sec_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .irqCount  (irqCount),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .grp0En    (grp0En),
    .grp1NsEn  (grp1NsEn),
    .grp1SEn   (grp1SEn),
    .routeEnNs (routeEnNs),
    .secOff    (secDisabled)
  );

  assign routeEnS = 1'b1;

endmodule

// File: rtl/dist_sec_ctrl_chk.sv
module dist_sec_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic accEn,
  input logic accWr,
  input logic accSecure,
  input logic grp0En,
  input logic grp1SEn,
  input logic routeEnNs,
  input logic secDisabled,
  input logic rdValid
);

  // R6: security-disable is sticky
  a_r6_secoff_sticky: assert property (@(posedge clk) disable iff (!rstN)
    secDisabled |=> secDisabled);

  // R5: entering single-state mode clears secure group 1 and NS routing
  a_r5_secoff_clears: assert property (@(posedge clk) disable iff (!rstN)
    $rose(secDisabled) |-> (!grp1SEn && !routeEnNs));

  // R7: with security off, secure group 1 stays zero
  a_r7_grp1s_zero: assert property (@(posedge clk) disable iff (!rstN)
    secDisabled |-> !grp1SEn);

  // R4: a non-secure write leaves the secure-only state alone
  a_r4_ns_write_mask: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && accWr && !accSecure && !secDisabled) |=>
      ($stable(grp0En) && $stable(grp1SEn) && $stable(secDisabled)));

  // R9: read valid one cycle after a read request
  a_r9_rd_valid: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && !accWr) |=> rdValid);

  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !(accEn && !accWr) |=> !rdValid);

  // R5: NS routing never comes back once cleared
  a_r5_route_ns_stays: assert property (@(posedge clk) disable iff (!rstN)
    !routeEnNs |=> !routeEnNs);

endmodule

bind dist_sec_ctrl dist_sec_ctrl_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .accEn       (accEn),
  .accWr       (accWr),
  .accSecure   (accSecure),
  .grp0En      (grp0En),
  .grp1SEn     (grp1SEn),
  .routeEnNs   (routeEnNs),
  .secDisabled (secDisabled),
  .rdValid     (rdValid)
);

// File: tb/sim_dist_sec_ctrl.sv
module sim_dist_sec_ctrl;

  localparam int ADDR_W = 2;
  localparam int CNT_W  = 11;
  localparam int NVEC   = 21;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              accEn = 1'b0;
  logic              accWr = 1'b0;
  logic              accSecure = 1'b0;
  logic [ADDR_W-1:0] accAddr = '0;
  logic [31:0]       wrData = '0;
  logic [CNT_W-1:0]  irqCount = 11'd256;
  logic [31:0]       rdData;
  logic              rdValid;
  logic              grp0En, grp1NsEn, grp1SEn, routeEnS, routeEnNs, secDisabled;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dist_sec_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .accEn(accEn), .accWr(accWr),
    .accSecure(accSecure), .accAddr(accAddr), .wrData(wrData),
    .irqCount(irqCount), .rdData(rdData), .rdValid(rdValid),
    .grp0En(grp0En), .grp1NsEn(grp1NsEn), .grp1SEn(grp1SEn),
    .routeEnS(routeEnS), .routeEnNs(routeEnNs), .secDisabled(secDisabled)
  );

  // Entry: {wr, secure, addr[1:0], data[31:0], expect[31:0], req[3:0]}
  // For writes, expect = {secDisabled, routeEnNs, grp1SEn, grp1NsEn, grp0En}
  // For reads, expect = rdData. irqCount = 256 throughout the table.
  localparam logic [71:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 2'd0, 32'h0,        32'h00000030, 4'd1}, // R1 secure reset view
    {1'b0, 1'b0, 2'd0, 32'h0,        32'h00000010, 4'd3}, // R3 NS reset view
    {1'b1, 1'b1, 2'd0, 32'hFFFFFFBF, 32'h0000000F, 4'd2}, // R2 all-ones minus bit 6
    {1'b0, 1'b1, 2'd0, 32'h0,        32'h00000037, 4'd2}, // R2 readback
    {1'b0, 1'b0, 2'd0, 32'h0,        32'h00000012, 4'd3}, // R3 NS alias
    {1'b1, 1'b0, 2'd0, 32'h00000000, 32'h0000000D, 4'd4}, // R4 NS clears bit 1 only
    {1'b0, 1'b1, 2'd0, 32'h0,        32'h00000035, 4'd4}, // R4 readback
    {1'b1, 1'b0, 2'd0, 32'hFFFFFFFF, 32'h0000000F, 4'd4}, // R4 NS cannot set bit 6
    {1'b1, 1'b1, 2'd0, 32'h00000001, 32'h00000009, 4'd2}, // R2 single bit
    {1'b0, 1'b1, 2'd1, 32'h0,        32'h00780407, 4'd8}, // R8 type word
    {1'b1, 1'b1, 2'd1, 32'hFFFFFFFF, 32'h00000009, 4'd8}, // R8 type write ignored
    {1'b0, 1'b0, 2'd1, 32'h0,        32'h00780407, 4'd8}, // R8 type unchanged
    {1'b0, 1'b1, 2'd2, 32'h0,        32'h00000000, 4'd9}, // R9 unmapped read
    {1'b1, 1'b1, 2'd3, 32'hFFFFFFFF, 32'h00000009, 4'd9}, // R9 unmapped write
    {1'b1, 1'b1, 2'd0, 32'h00000046, 32'h00000012, 4'd5}, // R5 disable security
    {1'b0, 1'b1, 2'd0, 32'h0,        32'h00000052, 4'd7}, // R7 full view secure
    {1'b0, 1'b0, 2'd0, 32'h0,        32'h00000052, 4'd7}, // R7 full view NS
    {1'b1, 1'b0, 2'd0, 32'h00000007, 32'h00000013, 4'd7}, // R7 NS writes bits 1:0
    {1'b1, 1'b1, 2'd0, 32'h00000000, 32'h00000010, 4'd6}, // R6 bit 6 stays
    {1'b0, 1'b1, 2'd0, 32'h0,        32'h00000050, 4'd6}, // R6 readback
    {1'b0, 1'b1, 2'd1, 32'h0,        32'h00780007, 4'd8}  // R8 sec-ext bit follows
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] outPack();
    return {27'd0, secDisabled, routeEnNs, grp1SEn, grp1NsEn, grp0En};
  endfunction

  // Drive one access at a falling edge; results are sampled at the next falling edge
  task automatic access(input logic wr, input logic sec, input logic [ADDR_W-1:0] a,
                        input logic [31:0] d);
    @(negedge clk);
    accEn = 1'b1; accWr = wr; accSecure = sec; accAddr = a; wrData = d;
    @(negedge clk);
    accEn = 1'b0; accWr = 1'b0; wrData = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    doReset();
    // R1: reset outputs
    @(negedge clk);
    check("R1 outputs", outPack(), 32'h08);
    check("R1 routeS", {31'd0, routeEnS}, 32'd1);
    check("R9 idle valid", {31'd0, rdValid}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [71:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      access(v[71], v[70], v[69:68], v[67:36]);
      if (v[71]) begin
        check(tag, outPack(), v[35:4]);
      end else begin
        check({tag, " valid"}, {31'd0, rdValid}, 32'd1);
        check(tag, rdData, v[35:4]);
      end
    end

    // R9: valid drops one cycle after the read
    @(negedge clk);
    check("R9 valid single", {31'd0, rdValid}, 32'd0);

    // R6: only reset clears security-disable
    doReset();
    @(negedge clk);
    check("R6 reset clears", outPack(), 32'h08);

    // R8: different interrupt counts
    irqCount = 11'd1024;
    access(1'b0, 1'b0, 2'd1, 32'h0);
    check("R8 count1024", rdData, 32'h0078041F);
    irqCount = 11'd32;
    access(1'b0, 1'b1, 2'd1, 32'h0);
    check("R8 count32", rdData, 32'h00780400);

    // R5: enabling secure group 1 then disabling security clears it; NS write cannot set bit 6
    access(1'b1, 1'b1, 2'd0, 32'h00000004);
    check("R2 grp1s set", outPack(), 32'h0C);
    access(1'b1, 1'b0, 2'd0, 32'h00000040);
    check("R4 NS bit6 ignored", outPack(), 32'h0C);
    access(1'b1, 1'b1, 2'd0, 32'h00000043);
    check("R5 transition", outPack(), 32'h13);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule